// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

The block gathers a wide vector of level-sensitive interrupt lines into groups of eight and drives one request line per group toward a downstream interrupt controller. Each group carries an eight-bit enable mask. A group's line is high while any of its pending inputs is also enabled. Input number n belongs to group n>>3 at bit position n&7. With the default of 64 groups there are 512 inputs and 64 output lines.

Software reaches the masks through a small synchronous register bus. The group space is divided into sixteen-byte quads. Each quad serves four consecutive groups, one byte lane per group. Within a quad, two write registers set or clear mask bits, and two read registers return raw and masked pending state. Above the last quad, two summary words give one masked-status bit per group. The set and clear registers read back the word last written to them rather than the live mask. Writes to any read-only or undecoded location change nothing and raise a one-cycle error flag.

A build-time option gives an external variant. In that variant, inputs that fall in groups at or above a configured limit never become pending.

Top module: `irq_group_combiner`

## Requirements
- R1: Input irq_in[n] feeds bit n&7 of the pending vector of group n>>3. Raising only input n makes grp_irq equal to the one-hot value 1<<(n>>3), and bit n&31 of the raw word of quad n>>5 is set.
- R2: The pending bits are level-sensitive. Each pending bit equals the level its input had at the previous clock edge, so it clears once the input is low.
- R3: grp_irq[g] is high exactly when (mask AND pending) of group g is nonzero. It is registered, so it reflects an input change or a mask write one cycle later. This also holds when both happen in the same cycle.
- R4: The quad index q is given by bus_addr[ADDR_W-1:4] and the register within the quad by bus_addr[3:2]. Byte lane k, which is bits [8k+7:8k], belongs to group 4q+k. bus_addr[1:0] are ignored.
- R5: Register 0 of a quad is set-enable: a written 1 sets that mask bit. Register 1 is clear-enable: a written 1 clears it. Zeros in the written word leave the mask unchanged.
- R6: Register 2 of a quad reads the raw pending bytes and register 3 reads mask AND pending, both in lane order. Read data appears on bus_rdata in the cycle after the request and holds until the next read.
- R7: A read of register 0 or 1 returns the last word written to that exact address, not the live mask.
- R8: The summary word at 0x100 holds grp_irq[31:0], and the word at 0x104 holds grp_irq[63:32]. Reads at 0x108 and above return zero.
- R9: After reset all masks, pending bits, outputs and stored words are zero, except the stored words at 0xC0, 0xC4, 0xD0 and 0xD4, which read 0x01010101.
- R10: A write to register 2 or 3 of a quad, or to any address at or above 0x100, changes no mask and no stored word. It sets bus_err for exactly the cycle after the request. Legal writes and all reads leave bus_err low.
- R11: With EXT_VARIANT set, inputs of groups at or above EXT_GROUP_LIMIT are ignored. Their pending bits, raw status and outputs stay zero whatever the input level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_GROUPS*8 | Level interrupt inputs |
| bus_valid | input | 1 | Register request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle pulse after an illegal write |
| grp_irq | output | NUM_GROUPS | Per-group combined request lines |

## Verification
A level change on an input and a set-enable or clear-enable write that touches the same group can land on the same clock edge. The group output must then reflect both new values together, with no stale cycle in between. The bench provokes this by changing irq_in and issuing the write in the same cycle. It does so for a rising input paired with a set, a falling input paired with a set, and a rising input paired with a clear. One cycle later it compares grp_irq and the masked status word against mask AND pending computed from its own mask model.

// File: rtl/comb_pkg.sv
package comb_pkg;
    localparam int GRP_W  = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = GRP_W * LANES;

    typedef enum logic [1:0] {
        REG_SET_EN = 2'd0,
        REG_CLR_EN = 2'd1,
        REG_RAW    = 2'd2,
        REG_MASKED = 2'd3
    } quad_reg_e;

    typedef struct packed {
        logic [GRP_W-1:0] pend;
        logic [GRP_W-1:0] mask;
        logic             active;
    } grp_state_t;
endpackage

// File: rtl/icomb_group.sv
module icomb_group
    import comb_pkg::*;
#(
    parameter bit ACCEPT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_W-1:0] lvl_in,
    input  logic [GRP_W-1:0] set_bits,
    input  logic [GRP_W-1:0] clr_bits,
    output logic [GRP_W-1:0] pend_o,
    output logic [GRP_W-1:0] mask_o,
    output logic             active_o
);
    grp_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.pend   = ACCEPT ? lvl_in : '0;
        st_d.mask   = (st_q.mask | set_bits) & ~clr_bits;
        st_d.active = |(st_d.pend & st_d.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o   = st_q.pend;
    assign mask_o   = st_q.mask;
    assign active_o = st_q.active;

    // R3: the request line agrees with the registered mask and pending state
    p_active_matches_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active_o == |(pend_o & mask_o));

    // R5: set bits are present in the mask one cycle after the write
    p_set_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_bits) |=> ((mask_o & $past(set_bits)) == $past(set_bits)));

    // R5: cleared bits are absent one cycle after the write
    p_clr_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_bits) |=> ((mask_o & $past(clr_bits)) == '0));

    generate
        if (ACCEPT) begin : g_live
            // R2: pending follows the input level with one register stage
            p_pend_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (pend_o == $past(lvl_in)));
        end else begin : g_dead
            // R11: a group beyond the limit never becomes pending
            p_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
                pend_o == '0 && !active_o);
        end
    endgenerate
endmodule

// File: rtl/icomb_bus_decode.sv
module icomb_bus_decode
    import comb_pkg::*;
#(
    parameter int          NUM_GROUPS    = 64,
    parameter int          ADDR_W        = 9,
    parameter int          PRESET_QUAD_A = 12,
    parameter int          PRESET_QUAD_B = 13,
    parameter logic [31:0] RB_PRESET     = 32'h0101_0101
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        valid,
    input  logic                        write,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [WORD_W-1:0]           wdata,
    input  logic [NUM_GROUPS*GRP_W-1:0] pend_all,
    input  logic [NUM_GROUPS*GRP_W-1:0] mask_all,
    input  logic [NUM_GROUPS-1:0]       active_all,
    output logic [NUM_GROUPS*GRP_W-1:0] set_all,
    output logic [NUM_GROUPS*GRP_W-1:0] clr_all,
    output logic [WORD_W-1:0]           rdata,
    output logic                        err
);
    localparam int NUM_QUADS = NUM_GROUPS / LANES;
    localparam int NUM_RB    = NUM_QUADS * 2;
    localparam int NUM_SUM   = (NUM_GROUPS + WORD_W - 1) / WORD_W;
    localparam int QSEL_W    = ADDR_W - 4;

    typedef struct packed {
        logic [NUM_RB-1:0][WORD_W-1:0] rb;
        logic [WORD_W-1:0]             rdata;
        logic                          err;
    } dec_state_t;

    function automatic dec_state_t reset_state();
        dec_state_t s;
        s = '0;
        if (PRESET_QUAD_A < NUM_QUADS) begin
            s.rb[PRESET_QUAD_A*2]     = RB_PRESET;
            s.rb[PRESET_QUAD_A*2 + 1] = RB_PRESET;
        end
        if (PRESET_QUAD_B < NUM_QUADS) begin
            s.rb[PRESET_QUAD_B*2]     = RB_PRESET;
            s.rb[PRESET_QUAD_B*2 + 1] = RB_PRESET;
        end
        return s;
    endfunction

    dec_state_t                st_d, st_q;
    logic [QSEL_W-1:0]         quad;
    quad_reg_e                 rsel;
    logic                      in_groups;
    logic                      legal_wr;
    logic [WORD_W-1:0]         rd_word;
    logic [NUM_SUM*WORD_W-1:0] sum_vec;

    assign quad      = addr[ADDR_W-1:4];
    assign rsel      = quad_reg_e'(addr[3:2]);
    assign in_groups = quad < QSEL_W'(NUM_QUADS);
    assign legal_wr  = valid && write && in_groups &&
                       (rsel == REG_SET_EN || rsel == REG_CLR_EN);

    always_comb begin
        sum_vec                 = '0;
        sum_vec[NUM_GROUPS-1:0] = active_all;
    end

    always_comb begin
        st_d    = st_q;
        set_all = '0;
        clr_all = '0;
        rd_word = '0;

        for (int q = 0; q < NUM_QUADS; q++) begin
            if (quad == QSEL_W'(q)) begin
                // write side: fan the lanes out to the four groups of this quad
                if (legal_wr) begin
                    for (int k = 0; k < LANES; k++) begin
                        if (rsel == REG_SET_EN)
                            set_all[(q*LANES+k)*GRP_W +: GRP_W] = wdata[k*GRP_W +: GRP_W];
                        else
                            clr_all[(q*LANES+k)*GRP_W +: GRP_W] = wdata[k*GRP_W +: GRP_W];
                    end
                    if (rsel == REG_SET_EN) st_d.rb[q*2]     = wdata;
                    else                    st_d.rb[q*2 + 1] = wdata;
                end
                // read side
                for (int k = 0; k < LANES; k++) begin
                    if (rsel == REG_RAW)
                        rd_word[k*GRP_W +: GRP_W] = pend_all[(q*LANES+k)*GRP_W +: GRP_W];
                    else if (rsel == REG_MASKED)
                        rd_word[k*GRP_W +: GRP_W] = pend_all[(q*LANES+k)*GRP_W +: GRP_W] &
                                                    mask_all[(q*LANES+k)*GRP_W +: GRP_W];
                end
                if (rsel == REG_SET_EN)      rd_word = st_q.rb[q*2];
                else if (rsel == REG_CLR_EN) rd_word = st_q.rb[q*2 + 1];
            end
        end

        for (int w = 0; w < NUM_SUM; w++) begin
            if (quad == QSEL_W'(NUM_QUADS) && rsel == quad_reg_e'(2'(w)))
                rd_word = sum_vec[w*WORD_W +: WORD_W];
        end

        if (valid && !write) st_d.rdata = rd_word;
        st_d.err = valid && write && !legal_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;
    assign err   = st_q.err;

    // R10: the error flag only follows a write request
    p_err_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(valid && write));

    // R10: a write to a status register reaches no mask
    p_status_wr_inert_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && write && (rsel == REG_RAW || rsel == REG_MASKED)) |->
        (set_all == '0 && clr_all == '0));

    // R7: stored readback words change only on a write request
    p_rb_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && write) |=> $stable(st_q.rb));

    // R6: reads never raise the error flag
    p_read_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !write) |=> !err);
endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
    import comb_pkg::*;
#(
    parameter int NUM_GROUPS      = 64,
    parameter int ADDR_W          = 9,
    parameter bit EXT_VARIANT     = 1'b0,
    parameter int EXT_GROUP_LIMIT = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_GROUPS*8-1:0]     irq_in,
    input  logic                        bus_valid,
    input  logic                        bus_write,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    output logic                        bus_err,
    output logic [NUM_GROUPS-1:0]       grp_irq
);
    localparam int VEC_W = NUM_GROUPS * GRP_W;

    logic [VEC_W-1:0] pend_all;
    logic [VEC_W-1:0] mask_all;
    logic [VEC_W-1:0] set_all;
    logic [VEC_W-1:0] clr_all;

    icomb_bus_decode #(
        .NUM_GROUPS (NUM_GROUPS),
        .ADDR_W     (ADDR_W)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (bus_valid),
        .write      (bus_write),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .pend_all   (pend_all),
        .mask_all   (mask_all),
        .active_all (grp_irq),
        .set_all    (set_all),
        .clr_all    (clr_all),
        .rdata      (bus_rdata),
        .err        (bus_err)
    );

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            localparam bit LIVE = !(EXT_VARIANT && (g >= EXT_GROUP_LIMIT));
            icomb_group #(.ACCEPT(LIVE)) u_grp (
                .clk      (clk),
                .rst_n    (rst_n),
                .lvl_in   (irq_in[g*GRP_W +: GRP_W]),
                .set_bits (set_all[g*GRP_W +: GRP_W]),
                .clr_bits (clr_all[g*GRP_W +: GRP_W]),
                .pend_o   (pend_all[g*GRP_W +: GRP_W]),
                .mask_o   (mask_all[g*GRP_W +: GRP_W]),
                .active_o (grp_irq[g])
            );
        end
    endgenerate

    // R5: set and clear never address the same group in one cycle
    p_setclr_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_all & clr_all) == '0);

    // R10: a flagged write leaves every mask untouched
    p_err_keeps_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $stable(mask_all));
endmodule

// File: tb/sim_irq_group_combiner.sv
module sim_irq_group_combiner;
    localparam int NG    = 64;
    localparam int LIMIT = 48;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NG*8-1:0]   irq = '0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [8:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       rdata0, rdata1;
    logic              err0, err1;
    logic [NG-1:0]     grp0, grp1;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0]  m_mask [NG];
    logic [31:0] m_rb   [32];

    always #4 clk = ~clk;

    irq_group_combiner #(.NUM_GROUPS(NG)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata0), .bus_err(err0), .grp_irq(grp0));

    irq_group_combiner #(.NUM_GROUPS(NG), .EXT_VARIANT(1'b1), .EXT_GROUP_LIMIT(LIMIT)) u1 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata1), .bus_err(err1), .grp_irq(grp1));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pend_of(input int g, input bit ext);
        return (ext && g >= LIMIT) ? 8'h00 : irq[g*8 +: 8];
    endfunction

    function automatic logic [31:0] exp_raw(input int q, input bit ext);
        logic [31:0] w;
        for (int k = 0; k < 4; k++) w[k*8 +: 8] = pend_of(q*4 + k, ext);
        return w;
    endfunction

    function automatic logic [31:0] exp_msk(input int q, input bit ext);
        logic [31:0] w;
        for (int k = 0; k < 4; k++) w[k*8 +: 8] = pend_of(q*4 + k, ext) & m_mask[q*4 + k];
        return w;
    endfunction

    function automatic logic [63:0] exp_out(input bit ext);
        logic [63:0] v;
        for (int g = 0; g < NG; g++) v[g] = |(pend_of(g, ext) & m_mask[g]);
        return v;
    endfunction

    function automatic void model_write(input logic [8:0] a, input logic [31:0] d);
        int q;
        q = int'(a[8:4]);
        if (a < 9'h100 && a[3] == 1'b0) begin
            m_rb[q*2 + int'(a[2])] = d;
            for (int k = 0; k < 4; k++) begin
                if (a[2] == 1'b0) m_mask[q*4 + k] = m_mask[q*4 + k] | d[k*8 +: 8];
                else              m_mask[q*4 + k] = m_mask[q*4 + k] & ~d[k*8 +: 8];
            end
        end
    endfunction

    task automatic wr(input logic [8:0] a, input logic [31:0] d, input logic [NG*8-1:0] v,
                      output logic e0, output logic e1);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; irq = v;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        e0 = err0; e1 = err1;
        model_write(a, d);
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d0, output logic [31:0] d1);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d0 = rdata0; d1 = rdata1;
    endtask

    task automatic set_irq(input logic [NG*8-1:0] v);
        @(negedge clk);
        irq = v;
        @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        logic [31:0] a, b;
        for (int q = 0; q < 16; q++) begin
            rd(9'(q*16 + 8), a, b);
            chk({tag, " R4 R6 raw"}, 64'(a), 64'(exp_raw(q, 1'b0)));
            chk({tag, " R11 raw ext"}, 64'(b), 64'(exp_raw(q, 1'b1)));
            rd(9'(q*16 + 12), a, b);
            chk({tag, " R6 masked"}, 64'(a), 64'(exp_msk(q, 1'b0)));
            chk({tag, " R11 masked ext"}, 64'(b), 64'(exp_msk(q, 1'b1)));
            rd(9'(q*16), a, b);
            chk({tag, " R7 set readback"}, 64'(a), 64'(m_rb[q*2]));
            rd(9'(q*16 + 4), a, b);
            chk({tag, " R7 clr readback"}, 64'(a), 64'(m_rb[q*2 + 1]));
        end
        rd(9'h100, a, b);
        chk({tag, " R8 summary lo"}, 64'(a), 64'(exp_out(1'b0)) & 64'hFFFF_FFFF);
        rd(9'h104, a, b);
        chk({tag, " R8 summary hi"}, 64'(a), 64'(exp_out(1'b0)) >> 32);
        chk({tag, " R11 summary hi ext"}, 64'(b), 64'(exp_out(1'b1)) >> 32);
        chk({tag, " R3 outputs"}, 64'(grp0), exp_out(1'b0));
        chk({tag, " R11 outputs ext"}, 64'(grp1), exp_out(1'b1));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic e0, e1;
        logic [31:0] a, b;
        logic [NG*8-1:0] v;

        for (int g = 0; g < NG; g++) m_mask[g] = 8'h00;
        for (int i = 0; i < 32; i++) m_rb[i] = 32'h0;
        m_rb[24] = 32'h0101_0101; m_rb[25] = 32'h0101_0101;
        m_rb[26] = 32'h0101_0101; m_rb[27] = 32'h0101_0101;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 outputs after reset", 64'(grp0), 64'h0);
        chk("R9 err after reset", 64'(err0), 64'h0);
        check_all("R9 reset");

        // level pattern with every mask closed
        for (int g = 0; g < NG; g++) v[g*8 +: 8] = 8'(g*29 + 3);
        set_irq(v);
        check_all("R2 pattern masks closed");

        // open masks through set-enable words
        for (int q = 0; q < 16; q++) begin
            wr(9'(q*16), {8'(q*13 + 1), 8'(q*7 + 2), 8'(q*5 + 3), 8'(q*11 + 4)}, irq, e0, e1);
            chk("R10 legal set no err", 64'(e0), 64'h0);
        end
        check_all("R5 after set");

        // close some bits through clear-enable words
        for (int q = 0; q < 16; q++) begin
            wr(9'(q*16 + 4), {8'(q*3 + 5), 8'(q*9 + 6), 8'(q*17 + 7), 8'(q*19 + 8)}, irq, e0, e1);
            chk("R10 legal clr no err", 64'(e0), 64'h0);
        end
        check_all("R5 after clear");

        // second input pattern with the same masks
        for (int g = 0; g < NG; g++) v[g*8 +: 8] = ~8'(g*41 + 9);
        set_irq(v);
        check_all("R2 second pattern");

        // all masks open, walk one input at a time
        for (int q = 0; q < 16; q++) wr(9'(q*16), 32'hFFFF_FFFF, irq, e0, e1);
        for (int n = 0; n < NG*8; n++) begin
            v = '0; v[n] = 1'b1;
            set_irq(v);
            chk("R1 walking output", 64'(grp0), 64'h1 << (n >> 3));
            chk("R11 walking output ext", 64'(grp1),
                ((n >> 3) >= LIMIT) ? 64'h0 : (64'h1 << (n >> 3)));
            rd(9'((n >> 5) * 16 + 8), a, b);
            chk("R1 walking raw", 64'(a), 64'(32'h1 << (n & 31)));
        end
        set_irq('0);
        check_all("R2 inputs low");

        // concurrency: input level change and mask write on the same edge
        for (int q = 0; q < 16; q++) wr(9'(q*16 + 4), 32'hFFFF_FFFF, irq, e0, e1);
        v = '0; v[5*8 + 2] = 1'b1;
        wr(9'h010, 32'h0000_0400, v, e0, e1);
        chk("R3 same cycle rise+set", 64'(grp0), 64'h1 << 5);
        rd(9'h01C, a, b);
        chk("R3 same cycle masked", 64'(a), 64'h0000_0400);
        wr(9'h010, 32'h0000_0100, '0, e0, e1);
        chk("R3 same cycle fall+set", 64'(grp0), 64'h0);
        v = '0; v[5*8 + 0] = 1'b1; v[5*8 + 2] = 1'b1;
        wr(9'h014, 32'h0000_0400, v, e0, e1);
        chk("R3 same cycle rise+clear", 64'(grp0), 64'h1 << 5);
        check_all("R3 concurrency");

        // illegal writes
        for (int i = 0; i < 6; i++) begin
            logic [8:0] ia;
            case (i)
                0: ia = 9'h008;
                1: ia = 9'h0CC;
                2: ia = 9'h100;
                3: ia = 9'h104;
                4: ia = 9'h108;
                default: ia = 9'h1F0;
            endcase
            wr(ia, 32'hFFFF_FFFF, irq, e0, e1);
            chk("R10 illegal err pulse", 64'(e0), 64'h1);
            @(negedge clk);
            chk("R10 err one cycle", 64'(err0), 64'h0);
        end
        check_all("R10 after illegal");

        // undecoded reads
        rd(9'h108, a, b); chk("R8 read 0x108", 64'(a), 64'h0);
        rd(9'h10C, a, b); chk("R8 read 0x10C", 64'(a), 64'h0);
        rd(9'h1FC, a, b); chk("R8 read 0x1FC", 64'(a), 64'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule